// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the protocol side of a byte-wide serial memory that answers on a two-wire bus. It watches oversampled copies of the clock and data lines and detects the bus start and stop events. It shifts bytes in on rising clock edges and out after falling clock edges. It releases or pulls the data line through an open-drain output enable.

A transfer opens with a device byte. That byte carries a fixed select code, three strap bits and a direction flag. A write header is followed by two bytes that together form a 14-bit word address. Any bytes after those are handed one at a time to a separate page-write unit. Reads fetch from a combinational array port.

An internal pointer serves current-address, random and sequential reads. While the page-write unit reports busy, the engine stays silent on its device byte, so a master can poll until the write has finished.

Top module: `sme_top`

## Requirements
- R1: A falling data line while the clock is high (start) restarts reception of a device byte from any state. A rising data line while the clock is high (stop) returns the engine to idle with `sda_oe` low. After reset `sda_oe`, `wr_strobe` and `wr_commit` are 0 and `mem_addr` is 0.
- R2: The device byte is taken MSB first. Bits 7:4 must equal 4'b1010, bits 3:1 must equal `strap[2:0]`, and bit 0 selects read (1) or write (0). On a match the engine holds `sda_oe` high through the ninth clock, which is the acknowledge.
- R3: On a device byte mismatch no acknowledge is given. All later bytes are ignored until the next start, even bytes that would otherwise match.
- R4: While `wr_busy` is high, a device byte is not acknowledged, even when it matches.
- R5: After a write header the next byte supplies address bits 13:8 from its bits 5:0; its bits 7:6 are ignored. The byte after that supplies address bits 7:0. Both bytes are acknowledged.
- R6: Each further write byte is acknowledged and produces a one-cycle `wr_strobe` with `wr_addr` and `wr_data`. After each byte the address advances in its low 6 bits only, so it wraps inside a 64-byte page and bits 13:6 are kept.
- R7: A stop that ends a write carrying at least one data byte gives a one-cycle `wr_commit`. A write holding only address bytes gives none.
- R8: Read data leaves MSB first, one bit per clock, each bit changing after a falling clock edge. `sda_oe` is the inverse of the bit. During the master's acknowledge bit `sda_oe` is low.
- R9: A master acknowledge (0) after a read byte makes the engine send the byte at the next address. A master no-acknowledge (1) ends the read: `sda_oe` stays low until the next start.
- R10: During reads the address advances over the whole array, wrapping from 0x3FFF to 0x0000.
- R11: Between transfers the pointer holds the last accessed address plus one, and a read header begins at that value. A write header with two address bytes, then a repeated start and a read header, reads from the loaded address.
- R12: `sda_oe` is low during every bit the master drives: device, address and write data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe | output | 1 | 1 pulls the data line low |
| strap | input | 3 | Device select strap bits |
| wr_busy | input | 1 | Page-write unit is executing a write cycle |
| mem_addr | output | 14 | Read address to the array |
| mem_rdata | input | 8 | Array data at `mem_addr`, combinational |
| wr_strobe | output | 1 | One-cycle pulse: a write byte is available |
| wr_addr | output | 14 | Address of the write byte |
| wr_data | output | 8 | Write byte |
| wr_commit | output | 1 | One-cycle pulse: write transfer closed by stop |

## Verification
The bench aims first at device byte decoding. It uses headers that differ from a match in a single field, a matching header offered while busy, and a matching byte sent after a mismatch. A decoder that compared too few bits, or that kept listening after a mismatch, would acknowledge one of these.

It writes across a page boundary with an address byte whose top two bits are set. A full-width increment would write to 0x0140 instead of 0x0100, and unmasked top bits would shift every write address.

A sequential read runs from 0x3FFE past the top of the array, followed by a current-address read. An engine that skipped the wrap, or advanced the pointer at the wrong moment, returns the wrong data.

The bench also watches `sda_oe` during master-driven bits and during the acknowledge bit of each read byte. A late release would corrupt the master's bits or turn a no-acknowledge into an acknowledge.

// File: rtl/sme_pkg.sv
package sme_pkg;

    localparam int ADDR_W     = 14;
    localparam int PAGE_BITS  = 6;
    localparam int BYTE_W     = 8;
    localparam int STRAP_W    = 3;
    localparam int CNT_W      = 4;
    localparam logic [3:0] SEL_CODE = 4'b1010;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RX,
        ST_TX
    } bus_state_e;

    typedef enum logic [1:0] {
        RL_DEV,
        RL_AHI,
        RL_ALO,
        RL_WDAT
    } rx_role_e;

    function automatic logic dev_match(input logic [BYTE_W-1:0] b,
                                       input logic [STRAP_W-1:0] s);
        return (b[7:4] == SEL_CODE) && (b[3:1] == s);
    endfunction

endpackage

// File: rtl/sme_sync.sv
module sme_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) pipe[0] <= '1;
        else     pipe[0] <= din;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) pipe[g] <= '1;
            else     pipe[g] <= pipe[g-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= '1;
        else     prev <= pipe[STAGES-1];
    end

    assign cur = pipe[STAGES-1];
endmodule

// File: rtl/sme_addr_ctr.sv
module sme_addr_ctr
    import sme_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int PB = PAGE_BITS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          inc_page,
    input  logic          inc_full,
    output logic [AW-1:0] ptr
);
    localparam int HB = AW - PB;

    logic [PB-1:0] low_next;
    assign low_next = ptr[PB-1:0] + 1'b1;

    always_ff @(posedge clk) begin
        if (rst)           ptr <= '0;
        else if (load)     ptr <= load_val;
        else if (inc_page) ptr <= {ptr[AW-1:PB], low_next};
        else if (inc_full) ptr <= ptr + 1'b1;
    end

    if (HB < 1) begin : g_bad
        initial $error("page bits must be fewer than address bits");
    end
endmodule

// File: rtl/sme_top.sv
module sme_top
    import sme_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               sda_oe,
    input  logic [STRAP_W-1:0] strap,
    input  logic               wr_busy,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic [BYTE_W-1:0]  mem_rdata,
    output logic               wr_strobe,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [BYTE_W-1:0]  wr_data,
    output logic               wr_commit
);
    localparam int HI_W = ADDR_W - BYTE_W;

    logic [1:0] ln_cur, ln_prev;
    logic scl_cur, sda_cur, scl_prev, sda_prev;
    logic start_ev, stop_ev, scl_rise, scl_fall;

    sme_sync #(.W(2), .STAGES(2)) u_sync (
        .clk (clk), .rst (rst),
        .din ({scl_in, sda_in}),
        .cur (ln_cur), .prev (ln_prev)
    );

    assign {scl_cur, sda_cur}   = ln_cur;
    assign {scl_prev, sda_prev} = ln_prev;
    assign scl_rise = scl_cur & ~scl_prev;
    assign scl_fall = ~scl_cur & scl_prev;
    assign start_ev = scl_cur & scl_prev & sda_prev & ~sda_cur;
    assign stop_ev  = scl_cur & scl_prev & ~sda_prev & sda_cur;

    bus_state_e         st;
    rx_role_e           role;
    logic [CNT_W-1:0]   bitcnt;
    logic [BYTE_W-1:0]  shreg, txb;
    logic [HI_W-1:0]    addr_hi;
    logic               rw, mack, wrote;
    logic [ADDR_W-1:0]  ptr;

    logic rx_done, tx_done, dev_ok;
    assign rx_done = (st == ST_RX) && scl_fall && (bitcnt == CNT_W'(8));
    assign tx_done = (st == ST_TX) && scl_fall && (bitcnt == CNT_W'(8));
    assign dev_ok  = dev_match(shreg, strap) && !wr_busy;

    sme_addr_ctr u_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (rx_done && role == RL_ALO),
        .load_val ({addr_hi, shreg}),
        .inc_page (rx_done && role == RL_WDAT),
        .inc_full (tx_done),
        .ptr      (ptr)
    );

    assign mem_addr = ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            role      <= RL_DEV;
            bitcnt    <= '0;
            shreg     <= '0;
            txb       <= '0;
            addr_hi   <= '0;
            rw        <= 1'b0;
            mack      <= 1'b0;
            wrote     <= 1'b0;
            sda_oe    <= 1'b0;
            wr_strobe <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            wr_commit <= 1'b0;
        end else begin
            wr_strobe <= 1'b0;
            wr_commit <= 1'b0;
            if (start_ev) begin
                st     <= ST_RX;
                role   <= RL_DEV;
                bitcnt <= '0;
                rw     <= 1'b0;
                sda_oe <= 1'b0;
                wrote  <= 1'b0;
            end else if (stop_ev) begin
                st        <= ST_IDLE;
                sda_oe    <= 1'b0;
                wr_commit <= wrote;
                wrote     <= 1'b0;
            end else if (st != ST_IDLE) begin
                if (scl_rise) begin
                    if (bitcnt < CNT_W'(8)) begin
                        bitcnt <= bitcnt + 1'b1;
                        if (st == ST_RX) shreg <= {shreg[BYTE_W-2:0], sda_cur};
                    end else if (bitcnt == CNT_W'(8)) begin
                        bitcnt <= CNT_W'(9);
                        mack   <= ~sda_cur;
                    end
                end else if (scl_fall) begin
                    if (bitcnt == CNT_W'(8)) begin
                        if (st == ST_RX) begin
                            unique case (role)
                                RL_DEV: begin
                                    if (dev_ok) begin
                                        sda_oe <= 1'b1;
                                        rw     <= shreg[0];
                                        role   <= RL_AHI;
                                    end else begin
                                        st <= ST_IDLE;
                                    end
                                end
                                RL_AHI: begin
                                    addr_hi <= shreg[HI_W-1:0];
                                    sda_oe  <= 1'b1;
                                    role    <= RL_ALO;
                                end
                                RL_ALO: begin
                                    sda_oe <= 1'b1;
                                    role   <= RL_WDAT;
                                end
                                RL_WDAT: begin
                                    sda_oe    <= 1'b1;
                                    wr_strobe <= 1'b1;
                                    wr_addr   <= ptr;
                                    wr_data   <= shreg;
                                    wrote     <= 1'b1;
                                end
                            endcase
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end else if (bitcnt == CNT_W'(9)) begin
                        bitcnt <= '0;
                        if (st == ST_RX) begin
                            if (rw) begin
                                st     <= ST_TX;
                                txb    <= mem_rdata;
                                sda_oe <= ~mem_rdata[BYTE_W-1];
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end else if (mack) begin
                            txb    <= mem_rdata;
                            sda_oe <= ~mem_rdata[BYTE_W-1];
                        end else begin
                            st     <= ST_IDLE;
                            sda_oe <= 1'b0;
                        end
                    end else if (st == ST_TX && bitcnt != '0) begin
                        sda_oe <= ~txb[3'(7 - bitcnt)];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/sme_chk.sv
module sme_chk
    import sme_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              sda_oe,
    input logic              wr_commit,
    input logic              wr_busy,
    input logic              stop_ev,
    input logic              scl_cur,
    input logic              scl_fall,
    input bus_state_e        st,
    input rx_role_e          role,
    input logic [CNT_W-1:0]  bitcnt,
    input logic [ADDR_W-1:0] ptr
);
    a_r1_stop_releases: assert property (@(posedge clk) disable iff (rst)
        stop_ev |=> !sda_oe);

    a_r7_commit_on_stop: assert property (@(posedge clk) disable iff (rst)
        wr_commit |-> $past(stop_ev));

    a_r4_busy_no_ack: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RX && role == RL_DEV && bitcnt == CNT_W'(8) && scl_fall && wr_busy)
        |=> !sda_oe);

    a_r12_master_bits_released: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RX && bitcnt < CNT_W'(8)) |-> !sda_oe);

    a_r10_read_advance: assert property (@(posedge clk) disable iff (rst)
        (st == ST_TX && scl_fall && bitcnt == CNT_W'(8)) |=> (ptr == $past(ptr) + 1'b1));

    a_r8_oe_moves_clock_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !$past(scl_cur));
endmodule

bind sme_top sme_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .sda_oe    (sda_oe),
    .wr_commit (wr_commit),
    .wr_busy   (wr_busy),
    .stop_ev   (stop_ev),
    .scl_cur   (scl_cur),
    .scl_fall  (scl_fall),
    .st        (st),
    .role      (role),
    .bitcnt    (bitcnt),
    .ptr       (ptr)
);

// File: tb/test_sme_top.sv
module test_sme_top;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 8;

    logic clk = 0;
    logic rst = 1;
    logic m_scl = 1, m_sda = 1;
    logic [2:0] strap = 3'b101;
    logic wr_busy = 0;
    logic sda_oe, wr_strobe, wr_commit;
    logic [13:0] mem_addr, wr_addr;
    logic [7:0] mem_rdata, wr_data;
    logic sda_line;

    int checks = 0, errors = 0;
    int nstb = 0, ncommit = 0;
    logic [13:0] la [0:3];
    logic [7:0]  ld [0:3];
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] pat(input logic [13:0] a);
        return a[7:0] ^ {2'b10, a[13:8]};
    endfunction

    assign sda_line  = m_sda & ~sda_oe;
    assign mem_rdata = pat(mem_addr);

    sme_top i_sme_top (
        .clk(clk), .rst(rst), .scl_in(m_scl), .sda_in(sda_line), .sda_oe(sda_oe),
        .strap(strap), .wr_busy(wr_busy), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .wr_strobe(wr_strobe), .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit)
    );

    always @(posedge clk) begin
        if (wr_strobe) begin
            if (nstb < 4) begin
                la[nstb] <= wr_addr;
                ld[nstb] <= wr_data;
            end
            nstb <= nstb + 1;
        end
        if (wr_commit) ncommit <= ncommit + 1;
    end

    // {busy, expected ack, device byte}
    localparam logic [9:0] VEC [0:6] = '{
        10'b0_1_10101010,
        10'b0_0_10101000,
        10'b0_0_10111010,
        10'b1_0_10101010,
        10'b0_0_00101010,
        10'b0_0_10101110,
        10'b0_1_10101010
    };

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic m_start();
        m_sda = 1; w(Q); m_scl = 1; w(Q); m_sda = 0; w(Q); m_scl = 0; w(Q);
    endtask

    task automatic m_stop();
        m_sda = 0; w(Q); m_scl = 1; w(Q); m_sda = 1; w(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack, output bit oe_seen);
        oe_seen = 0;
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; w(Q); m_scl = 1; w(Q);
            if (sda_oe) oe_seen = 1;
            w(Q); m_scl = 0; w(Q);
        end
        m_sda = 1; w(Q); m_scl = 1; w(Q); ack = !sda_line; w(Q); m_scl = 0; w(Q);
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b, output bit oe_ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1; w(Q); m_scl = 1; w(Q); b[i] = sda_line; w(Q); m_scl = 0; w(Q);
        end
        m_sda = !mack; w(Q); m_scl = 1; w(Q); oe_ack = sda_oe; w(Q); m_scl = 0; w(Q);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit ack, oe;
        logic [7:0] d;
        int c0;
        w(5);
        // R1 reset state
        chk(sda_oe == 0 && wr_strobe == 0 && wr_commit == 0, "R1 reset outputs", sda_oe, 0);
        chk(mem_addr == 0, "R1 reset pointer", mem_addr, 0);
        rst = 0;
        w(4);

        // R2 R3 R4 device byte table
        foreach (VEC[k]) begin
            wr_busy = VEC[k][9];
            m_start();
            send_byte(VEC[k][7:0], ack, oe);
            chk(ack == VEC[k][8], "R2 R4 device ack", ack, VEC[k][8]);
            chk(!oe, "R12 released on device bits", oe, 0);
            if (!VEC[k][8]) begin
                send_byte(8'hAA, ack, oe);
                chk(!ack, "R3 ignored after mismatch", ack, 0);
            end
            m_stop();
            wr_busy = 0;
            w(Q);
        end
        chk(ncommit == 0 && nstb == 0, "R7 no commit for header only", ncommit, 0);

        // R5 R6 write across page end, upper address bits ignored
        m_start();
        send_byte(8'hAA, ack, oe); chk(ack, "R2 write header", ack, 1);
        send_byte(8'hC1, ack, oe); chk(ack && !oe, "R5 addr hi ack", ack, 1);
        send_byte(8'h3E, ack, oe); chk(ack && !oe, "R5 addr lo ack", ack, 1);
        send_byte(8'h11, ack, oe); chk(ack && !oe, "R6 data ack", ack, 1);
        send_byte(8'h22, ack, oe); chk(ack, "R6 data ack", ack, 1);
        send_byte(8'h33, ack, oe); chk(ack, "R6 data ack", ack, 1);
        c0 = ncommit;
        m_stop();
        w(2);
        chk(nstb == 3, "R6 strobe count", nstb, 3);
        chk(la[0] == 14'h013E && ld[0] == 8'h11, "R5 first write addr", la[0], 14'h013E);
        chk(la[1] == 14'h013F && ld[1] == 8'h22, "R6 second write addr", la[1], 14'h013F);
        chk(la[2] == 14'h0100 && ld[2] == 8'h33, "R6 page wrap addr", la[2], 14'h0100);
        chk(ncommit == c0 + 1, "R7 commit after stop", ncommit, c0 + 1);

        // R11 current address read after write
        m_start();
        send_byte(8'hAB, ack, oe); chk(ack, "R2 read header", ack, 1);
        recv_byte(0, d, oe);
        chk(d == pat(14'h0101), "R11 current read data", d, pat(14'h0101));
        chk(!oe, "R8 released for master ack", oe, 0);
        m_stop();
        w(Q);

        // R9 R10 R11 random read then sequential with wrap
        c0 = ncommit;
        m_start();
        send_byte(8'hAA, ack, oe);
        send_byte(8'h3F, ack, oe);
        send_byte(8'hFE, ack, oe); chk(ack, "R11 dummy write addr", ack, 1);
        m_start();
        send_byte(8'hAB, ack, oe); chk(ack, "R11 repeated start read header", ack, 1);
        recv_byte(1, d, oe);
        chk(d == pat(14'h3FFE), "R11 random read data", d, pat(14'h3FFE));
        chk(!oe, "R8 released for master ack", oe, 0);
        recv_byte(1, d, oe);
        chk(d == pat(14'h3FFF), "R9 sequential data", d, pat(14'h3FFF));
        recv_byte(0, d, oe);
        chk(d == pat(14'h0000), "R10 wrap to zero", d, pat(14'h0000));
        w(Q);
        chk(!sda_oe, "R9 idle after nack", sda_oe, 0);
        m_stop();
        w(2);
        chk(ncommit == c0, "R7 no commit after dummy write", ncommit, c0);

        // R11 pointer kept after read
        m_start();
        send_byte(8'hAB, ack, oe);
        recv_byte(0, d, oe);
        chk(d == pat(14'h0001), "R11 pointer after read", d, pat(14'h0001));
        m_stop();
        w(Q);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule